// File: doc/BRIEF.md
# Event Status Flags with Saturating Event Counters

This block keeps three event flags in a small status word and keeps a tally of each kind of event. It watches three event sources: an address-filter rejection pulse, a transmit-buffer error pulse, and a half-period delay warning level. A receiver-enable pulse arrives from the receive controller, and a host-side clear mask lets software write ones to clear flags. Each flag has its own clearing rule. The rejection flag is cleared by a host write or automatically by the next receiver enable, whether the host commanded that enable or it was an automatic re-enable. The buffer-error flag is cleared only by a host write. The warning bit ignores writes and tracks its source level.

Three 12-bit counters tally rejections, buffer errors and rising edges of the warning level. They advance only while a global count-enable input is high, and they stop at their maximum value instead of wrapping. A separate clear strobe zeroes all three counters. Decoding of the register bus and interrupt masking are done outside this block.

Top module: `evt_status_unit`

## Requirements
- R1: A one-cycle pulse on `filt_rej_pulse` sets `status[0]` from the clock edge that samples it. The flag stays set until a clear condition occurs.
- R2: `host_wr_en` with `host_wr_mask[0]`=1 clears `status[0]`, and with `host_wr_mask[1]`=1 clears `status[1]`. A write with a mask bit of 0 leaves that flag unchanged.
- R3: A `rx_enable_pulse` clears `status[0]` at the next edge.
- R4: `buf_err_pulse` sets `status[1]`. It is cleared only by a host write (R2), and `rx_enable_pulse` has no effect on it.
- R5: `status[2]` equals `half_warn_lvl` as it was at the previous clock edge. Host writes, including `host_wr_mask[2]`=1, have no effect on it.
- R6: When a set pulse and a clear (host write or receiver enable) reach the same flag in the same cycle, the flag ends up set.
- R7: While `cnt_enable` is 1, `count_rej` and `count_berr` each increase by one for each event pulse. `count_warn` increases by one for each 0-to-1 change of `status[2]`. While `cnt_enable` is 0, all counters hold their values.
- R8: Counters are CNT_W (12) bits wide and stay at 4095 when further events arrive.
- R9: `cnt_clear` zeroes all three counters at the next edge, and it takes priority over an increment in the same cycle.
- R10: Synchronous active-high `rst` zeroes the status word and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_rej_pulse | input | 1 | Address-filter rejection event pulse |
| buf_err_pulse | input | 1 | Transmit-buffer late-write error pulse |
| half_warn_lvl | input | 1 | Half-period delay warning level |
| rx_enable_pulse | input | 1 | Receiver enable, commanded or automatic |
| host_wr_en | input | 1 | Host write strobe for the clear mask |
| host_wr_mask | input | 3 | Write-1-to-clear mask, one bit per status bit |
| cnt_enable | input | 1 | Global counter enable |
| cnt_clear | input | 1 | Zeroes all counters |
| status | output | 3 | Bit 0 rejection, bit 1 buffer error, bit 2 warning |
| count_rej | output | 12 | Rejection count |
| count_berr | output | 12 | Buffer-error count |
| count_warn | output | 12 | Warning rising-edge count |

## Verification
A flag can be set and cleared in the same cycle. This happens when an event pulse arrives together with a host write whose mask bit is 1, or together with a receiver-enable pulse. A counter can also be cleared and incremented in the same cycle, when `cnt_clear` arrives together with an enabled event. The stimulus table drives these pairs in single cycles. One cycle later it checks that the flag reads 1 and that the counter reads 0, and it also checks the cycles before and after each pair.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int NUM_EVT  = 3;
  localparam int IDX_REJ  = 0;
  localparam int IDX_BERR = 1;
  localparam int IDX_WARN = 2;

  typedef enum logic [1:0] {
    FLAG_W1C       = 2'd0,
    FLAG_W1C_RXCLR = 2'd1,
    FLAG_LEVEL     = 2'd2
  } flag_mode_e;

  function automatic flag_mode_e mode_of(input int idx);
    case (idx)
      IDX_REJ:  return FLAG_W1C_RXCLR;
      IDX_BERR: return FLAG_W1C;
      default:  return FLAG_LEVEL;
    endcase
  endfunction
endpackage

// File: rtl/evt_flag.sv
module evt_flag
  import evt_status_pkg::*;
#(
  parameter flag_mode_e MODE = FLAG_W1C
) (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic wr_clr,
  input  logic rx_clr,
  output logic q
);
  generate
    if (MODE == FLAG_LEVEL) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set_in;
      end
    end else begin : g_sticky
      logic clr_any;
      if (MODE == FLAG_W1C_RXCLR) begin : g_rx
        assign clr_any = wr_clr | rx_clr;
      end else begin : g_norx
        assign clr_any = wr_clr;
      end
      always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_in)  q <= 1'b1;
        else if (clr_any) q <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_in |=> q); // R6
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !set_in) |=> !q); // R2
      AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (q && !wr_clr && !rx_clr) |=> q); // R1
    end
  endgenerate
endmodule

// File: rtl/evt_sat_counter.sv
module evt_sat_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (en && evt && count != CNT_MAX)
      count <= count + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R9
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 filt_rej_pulse,
  input  logic                 buf_err_pulse,
  input  logic                 half_warn_lvl,
  input  logic                 rx_enable_pulse,
  input  logic                 host_wr_en,
  input  logic [NUM_EVT-1:0]   host_wr_mask,
  input  logic                 cnt_enable,
  input  logic                 cnt_clear,
  output logic [NUM_EVT-1:0]   status,
  output logic [CNT_W-1:0]     count_rej,
  output logic [CNT_W-1:0]     count_berr,
  output logic [CNT_W-1:0]     count_warn
);
  logic [NUM_EVT-1:0] set_vec;
  logic [NUM_EVT-1:0] cnt_evt;
  logic [CNT_W-1:0]   cnt_arr [NUM_EVT];

  assign set_vec[IDX_REJ]  = filt_rej_pulse;
  assign set_vec[IDX_BERR] = buf_err_pulse;
  assign set_vec[IDX_WARN] = half_warn_lvl;

  // warning counts rising edges of its level; the others count pulses
  assign cnt_evt[IDX_REJ]  = filt_rej_pulse;
  assign cnt_evt[IDX_BERR] = buf_err_pulse;
  assign cnt_evt[IDX_WARN] = half_warn_lvl & ~status[IDX_WARN];

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      evt_flag #(.MODE(mode_of(i))) u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_vec[i]),
        .wr_clr (host_wr_en & host_wr_mask[i]),
        .rx_clr (rx_enable_pulse),
        .q      (status[i])
      );
      evt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_enable),
        .clr   (cnt_clear),
        .evt   (cnt_evt[i]),
        .count (cnt_arr[i])
      );
    end
  endgenerate

  assign count_rej  = cnt_arr[IDX_REJ];
  assign count_berr = cnt_arr[IDX_BERR];
  assign count_warn = cnt_arr[IDX_WARN];

  AST_WARN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status[IDX_WARN] == $past(half_warn_lvl)); // R5
  AST_RX_CLEARS_REJ: assert property (@(posedge clk) disable iff (rst)
    (rx_enable_pulse && !filt_rej_pulse) |=> !status[IDX_REJ]); // R3
  AST_RX_KEEPS_BERR: assert property (@(posedge clk) disable iff (rst)
    (status[IDX_BERR] && !(host_wr_en && host_wr_mask[IDX_BERR])) |=> status[IDX_BERR]); // R4
  AST_REJ_SETS: assert property (@(posedge clk) disable iff (rst)
    filt_rej_pulse |=> status[IDX_REJ]); // R1
  AST_REJ_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_enable && !cnt_clear && filt_rej_pulse && count_rej != {CNT_W{1'b1}})
      |=> count_rej == $past(count_rej) + 1'b1); // R7
endmodule

// File: tb/evt_status_unit_bench.sv
module evt_status_unit_bench;
  localparam int W = 12;

  typedef struct packed {
    logic       rej, berr, warn, rxen, wen;
    logic [2:0] mask;
    logic       cen, cclr;
    logic [2:0] st;
    logic [W-1:0] cr, cb, cw;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  // fields: rej berr warn rxen wen mask cen cclr | st cr cb cw | req
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0, 3'b001,12'd1,12'd0,12'd0, 4'd1}, // R1 set + count
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0, 3'b001,12'd1,12'd0,12'd0, 4'd1}, // R1 holds
    '{1'b0,1'b0,1'b0,1'b0,1'b1,3'b010,1'b1,1'b0, 3'b001,12'd1,12'd0,12'd0, 4'd2}, // R2 other bit only
    '{1'b0,1'b0,1'b0,1'b0,1'b1,3'b001,1'b1,1'b0, 3'b000,12'd1,12'd0,12'd0, 4'd2}, // R2 w1c
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0, 3'b001,12'd1,12'd0,12'd0, 4'd7}, // R7 frozen
    '{1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b1,1'b0, 3'b000,12'd1,12'd0,12'd0, 4'd3}, // R3 rx clear
    '{1'b1,1'b0,1'b0,1'b1,1'b0,3'b000,1'b1,1'b0, 3'b001,12'd2,12'd0,12'd0, 4'd6}, // R6 set beats rx
    '{1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0, 3'b011,12'd2,12'd1,12'd0, 4'd4}, // R4 berr set
    '{1'b0,1'b0,1'b1,1'b0,1'b1,3'b111,1'b1,1'b0, 3'b100,12'd2,12'd1,12'd1, 4'd5}, // R5 follows, R2 clears
    '{1'b0,1'b0,1'b1,1'b0,1'b1,3'b100,1'b1,1'b0, 3'b100,12'd2,12'd1,12'd1, 4'd5}, // R5 write ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0, 3'b000,12'd2,12'd1,12'd1, 4'd5}, // R5 falls
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,1'b0,1'b0, 3'b100,12'd2,12'd1,12'd1, 4'd7}, // R7 edge not counted
    '{1'b0,1'b1,1'b1,1'b0,1'b1,3'b010,1'b1,1'b0, 3'b110,12'd2,12'd2,12'd1, 4'd6}, // R6 set beats w1c
    '{1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,1'b1,1'b0, 3'b110,12'd2,12'd2,12'd1, 4'd4}, // R4 rx no effect
    '{1'b1,1'b0,1'b1,1'b0,1'b0,3'b000,1'b1,1'b1, 3'b111,12'd0,12'd0,12'd0, 4'd9}, // R9 clear beats inc
    '{1'b0,1'b0,1'b0,1'b0,1'b1,3'b011,1'b1,1'b0, 3'b000,12'd0,12'd0,12'd0, 4'd2}  // R2 both cleared
  };

  logic clk = 1'b0;
  logic rst;
  logic filt_rej_pulse, buf_err_pulse, half_warn_lvl, rx_enable_pulse;
  logic host_wr_en, cnt_enable, cnt_clear;
  logic [2:0] host_wr_mask;
  logic [2:0] status;
  logic [W-1:0] count_rej, count_berr, count_warn;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_status_unit #(.CNT_W(W)) u_evt_status_unit (
    .clk(clk), .rst(rst),
    .filt_rej_pulse(filt_rej_pulse), .buf_err_pulse(buf_err_pulse),
    .half_warn_lvl(half_warn_lvl), .rx_enable_pulse(rx_enable_pulse),
    .host_wr_en(host_wr_en), .host_wr_mask(host_wr_mask),
    .cnt_enable(cnt_enable), .cnt_clear(cnt_clear),
    .status(status), .count_rej(count_rej),
    .count_berr(count_berr), .count_warn(count_warn)
  );

  task automatic check_all(input string tag, input logic [2:0] st,
                           input logic [W-1:0] cr, cb, cw);
    n_checks++;
    if (status !== st || count_rej !== cr || count_berr !== cb || count_warn !== cw) begin
      n_fail++;
      $display("FAIL %s: got st=%b rej=%0d berr=%0d warn=%0d, expected st=%b rej=%0d berr=%0d warn=%0d",
               tag, status, count_rej, count_berr, count_warn, st, cr, cb, cw);
    end
  endtask

  task automatic idle();
    filt_rej_pulse = 0; buf_err_pulse = 0; half_warn_lvl = 0; rx_enable_pulse = 0;
    host_wr_en = 0; host_wr_mask = '0; cnt_enable = 0; cnt_clear = 0;
  endtask

  initial begin
    rst = 1;
    idle();
    repeat (3) @(negedge clk);
    check_all("R10 reset", 3'b000, 0, 0, 0);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      filt_rej_pulse = VEC[i].rej; buf_err_pulse = VEC[i].berr;
      half_warn_lvl = VEC[i].warn; rx_enable_pulse = VEC[i].rxen;
      host_wr_en = VEC[i].wen; host_wr_mask = VEC[i].mask;
      cnt_enable = VEC[i].cen; cnt_clear = VEC[i].cclr;
      @(negedge clk);
      check_all($sformatf("R%0d vector %0d", VEC[i].req, i),
                VEC[i].st, VEC[i].cr, VEC[i].cb, VEC[i].cw);
    end

    // R8 saturation: 4100 enabled rejection pulses stop at 4095
    idle();
    cnt_enable = 1;
    filt_rej_pulse = 1;
    repeat (4100) @(negedge clk);
    check_all("R8 saturate", 3'b001, 12'd4095, 0, 0);
    @(negedge clk);
    check_all("R8 no wrap", 3'b001, 12'd4095, 0, 0);

    // R9 clear while events keep coming
    cnt_clear = 1;
    @(negedge clk);
    check_all("R9 clear wins", 3'b001, 0, 0, 0);
    cnt_clear = 0;
    @(negedge clk);
    check_all("R7 resumes", 3'b001, 1, 0, 0);

    // R10 reset mid-run
    buf_err_pulse = 1;
    half_warn_lvl = 1;
    @(negedge clk);
    check_all("R7 pre-reset", 3'b111, 2, 1, 1);
    idle();
    rst = 1;
    @(negedge clk);
    check_all("R10 mid-run reset", 3'b000, 0, 0, 0);
    rst = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule